// File: doc/BRIEF.md
# Audio DSP Fractional ALU

This block is the arithmetic core of an audio effects DSP. Each cycle it takes a 4-bit opcode and three signed operands A, X and Y and forms a result R from them, with no register between the operands and R. It covers fractional (Q31) and integer multiply-accumulate, each with a clamping or a wrapping variant. It also covers a three-input add, a masked XOR, three compare-and-select forms, linear interpolation between A and Y, and a move that feeds a product into a side accumulator.

Besides R, the unit reports a condition vector. The vector flags a sign, a zero and a nonzero result, a normalized result, a clamp, and a wrap of an exact sum. The side accumulator is the only state. It changes only when an issued instruction carries the move-accumulate opcode, and its value is visible on a port. The log/exp conversion opcodes and the skip opcode are handled outside this unit, and here they return A unchanged.

Top module: `fx_alu`

## Requirements
- R1: Opcode 0x0 gives R = A + floor(X*Y / 2^31), clamped. Opcode 0x2 gives the same sum truncated to its low 32 bits. The product is formed at full signed width before the arithmetic right shift by 31.
- R2: Opcode 0x1 gives R = A + floor(-(X*Y) / 2^31), clamped. Opcode 0x3 gives the same sum truncated to 32 bits.
- R3: Opcode 0x4 gives the clamped integer sum A + X*Y. Opcode 0x5 gives bits 30:0 of that exact sum, with bit 31 a copy of bit 30.
- R4: Opcode 0x6 gives the clamped sum A + X + Y.
- R5: Opcode 0x7 gives R = A. When `issue` is high at a rising clock edge with this opcode, the accumulator becomes clamp(acc + floor(X*Y / 2^31)).
- R6: Opcode 0x8 gives R = (A & X) ^ Y.
- R7: Comparisons are signed. Opcode 0x9 gives X if A >= Y, else ~X. Opcode 0xA gives X if A >= Y, else Y. Opcode 0xB gives X if A < Y, else Y.
- R8: Opcode 0xE gives R = clamp(A + floor(X*(Y-A) / 2^31)), with Y-A taken exactly, without wrap.
- R9: Opcodes 0xC, 0xD and 0xF give R = A.
- R10: Clamping maps a sum above 0x7FFFFFFF to 0x7FFFFFFF and a sum below -2^31 to 0x80000000. Condition bit 4 is set only when one of opcodes 0x0, 0x1, 0x4, 0x6 or 0xE clamped.
- R11: Condition bit 1 (borrow/wrap) is set only when opcode 0x2, 0x3 or 0x5 produced an R that differs from the exact sum.
- R12: The condition vector `cc` is 9 bits wide. Bit 0 = R[31] XOR R[30] (normalized). Bit 2 = R[31] (minus). Bit 3 = (R == 0). Bit 8 = (R != 0). Bits 7:5 are 0.
- R13: The accumulator is 0 after reset. It holds its value on every edge without an issued opcode 0x7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the accumulator |
| rst_n | input | 1 | Active-low reset, clears the accumulator |
| issue | input | 1 | Instruction valid; gates the accumulator update |
| op | input | 4 | Opcode |
| a | input | 32 | Operand A, signed |
| x | input | 32 | Operand X, signed |
| y | input | 32 | Operand Y, signed |
| r | output | 32 | Result, combinational |
| cc | output | 9 | Condition vector |
| acc | output | 32 | Side accumulator value |

## Verification
The operands are drawn from a mix of full-range random words and the values 0, 1, -1, 0x7FFFFFFF and 0x80000000. The extreme values drive each multiply-accumulate across both clamp limits, which separates the clamping variants from the wrapping ones. They also exercise the floor rounding of negative fractional products, where negating before and after the shift give different results. Directed cases square 0x80000000 and place A equal to Y, which exposes an off-by-one in the signed compares. Move-accumulate is issued both with `issue` high and with it low, so a leaky accumulator gate shows up on the `acc` port.

// File: rtl/fx_alu.sv
module fx_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] r,
  output logic [8:0]   cc,
  output logic [W-1:0] acc
);
  localparam int PW = 2*W + 2;
  localparam int SH = W - 1;
  localparam logic signed [PW-1:0] MAXX = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PW-1:0] MINX = ~MAXX;
  localparam logic signed [PW-1:0] MAX31 = {{(PW-W+2){1'b0}}, {(W-2){1'b1}}};
  localparam logic signed [PW-1:0] MIN31 = ~MAX31;
  localparam logic [W-1:0] MAXW = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINW = {1'b1, {(W-1){1'b0}}};

  function automatic logic fits(input logic signed [PW-1:0] v);
    return (v <= MAXX) && (v >= MINX);
  endfunction

  function automatic logic [W-1:0] clamp(input logic signed [PW-1:0] v);
    if (v > MAXX) return MAXW;
    if (v < MINX) return MINW;
    return v[W-1:0];
  endfunction

  logic [W-1:0] acc_q;
  logic signed [PW-1:0] ax, xx, yx, accx;
  logic signed [PW-1:0] prod, frac, nfrac, diff, iprod, ifrac;
  logic signed [PW-1:0] s_fp, s_fn, s_int, s_add3, s_itp, s_acc;
  logic ge;
  logic sat, wrp;

  assign ax   = $signed({{(PW-W){a[W-1]}}, a});
  assign xx   = $signed({{(PW-W){x[W-1]}}, x});
  assign yx   = $signed({{(PW-W){y[W-1]}}, y});
  assign accx = $signed({{(PW-W){acc_q[W-1]}}, acc_q});

  assign prod  = xx * yx;
  assign frac  = prod >>> SH;
  assign nfrac = (-prod) >>> SH;
  assign diff  = yx - ax;
  assign iprod = xx * diff;
  assign ifrac = iprod >>> SH;

  assign s_fp   = ax + frac;
  assign s_fn   = ax + nfrac;
  assign s_int  = ax + prod;
  assign s_add3 = ax + xx + yx;
  assign s_itp  = ax + ifrac;
  assign s_acc  = accx + frac;

  assign ge = ($signed(a) >= $signed(y));

  always_comb begin
    r   = a;
    sat = 1'b0;
    wrp = 1'b0;
    case (op)
      4'h0: begin r = clamp(s_fp);   sat = !fits(s_fp);   end
      4'h1: begin r = clamp(s_fn);   sat = !fits(s_fn);   end
      4'h2: begin r = s_fp[W-1:0];   wrp = !fits(s_fp);   end
      4'h3: begin r = s_fn[W-1:0];   wrp = !fits(s_fn);   end
      4'h4: begin r = clamp(s_int);  sat = !fits(s_int);  end
      4'h5: begin
        r   = {s_int[W-2], s_int[W-2:0]};
        wrp = (s_int > MAX31) || (s_int < MIN31);
      end
      4'h6: begin r = clamp(s_add3); sat = !fits(s_add3); end
      4'h7: r = a;
      4'h8: r = (a & x) ^ y;
      4'h9: r = ge ? x : ~x;
      4'hA: r = ge ? x : y;
      4'hB: r = ge ? y : x;
      4'hE: begin r = clamp(s_itp);  sat = !fits(s_itp);  end
      default: r = a;
    endcase
  end

  assign cc = {(r != '0), 3'b000, sat, (r == '0), r[W-1], wrp, r[W-1] ^ r[W-2]};

  always_ff @(posedge clk) begin
    if (!rst_n)
      acc_q <= '0;
    else if (issue && op == 4'h7)
      acc_q <= clamp(s_acc);
  end

  assign acc = acc_q;

  // R13
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && op == 4'h7) |=> $stable(acc_q));

  // R13
  acc_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> acc_q == '0);

  // R10
  sat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cc[4] |-> (r == MAXW || r == MINW));

  // R7
  sel_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'hA || op == 4'hB) |-> (r == x || r == y));

  // R5
  mov_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'h7 |-> r == a);
endmodule

// File: tb/fx_alu_tb.sv
module fx_alu_tb;
  localparam int PERIOD = 10;
  localparam logic signed [127:0] BMAX = 128'sh7fffffff;
  localparam logic signed [127:0] BMIN = -BMAX - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue = 1'b0;
  logic [3:0] op = '0;
  logic [31:0] a = '0, x = '0, y = '0;
  logic [31:0] r, acc;
  logic [8:0] cc;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] m_acc;

  fx_alu u_dut (.clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .a(a), .x(x), .y(y),
                .r(r), .cc(cc), .acc(acc));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] lim(input logic signed [127:0] v, output bit s);
    s = (v > BMAX) || (v < BMIN);
    if (v > BMAX) return 32'h7fffffff;
    if (v < BMIN) return 32'h80000000;
    return v[31:0];
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'h0, 4'h2: return "R1";
      4'h1, 4'h3: return "R2";
      4'h4, 4'h5: return "R3";
      4'h6: return "R4";
      4'h7: return "R5";
      4'h8: return "R6";
      4'h9, 4'hA, 4'hB: return "R7";
      4'hE: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic model(input logic [3:0] o, input logic [31:0] ia, ix, iy, input logic [31:0] iacc,
                       output logic [31:0] er, output logic [8:0] ecc, output logic [31:0] eacc);
    logic signed [127:0] A, X, Y, P, S, T;
    bit s, wr, dummy;
    logic signed [31:0] sa, sy;
    A = $signed(ia); X = $signed(ix); Y = $signed(iy);
    sa = ia; sy = iy;
    P = X * Y;
    s = 0; wr = 0; eacc = iacc;
    case (o)
      4'h0: er = lim(A + (P >>> 31), s);
      4'h1: er = lim(A + ((-P) >>> 31), s);
      4'h2: begin S = A + (P >>> 31); er = S[31:0]; wr = (S > BMAX) || (S < BMIN); end
      4'h3: begin S = A + ((-P) >>> 31); er = S[31:0]; wr = (S > BMAX) || (S < BMIN); end
      4'h4: er = lim(A + P, s);
      4'h5: begin
        S = A + P; er = {S[30], S[30:0]};
        wr = (S > 128'sh3fffffff) || (S < -128'sh40000000);
      end
      4'h6: er = lim(A + X + Y, s);
      4'h7: begin
        er = ia;
        T = $signed(iacc);
        eacc = lim(T + (P >>> 31), dummy);
      end
      4'h8: er = (ia & ix) ^ iy;
      4'h9: er = (sa >= sy) ? ix : ~ix;
      4'hA: er = (sa >= sy) ? ix : iy;
      4'hB: er = (sa < sy) ? ix : iy;
      4'hE: er = lim(A + ((X * (Y - A)) >>> 31), s);
      default: er = ia;
    endcase
    ecc = {(er != 0), 3'b000, s, (er == 0), er[31], wr, er[31] ^ er[30]};
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (op=%h a=%h x=%h y=%h)", tag, act, exp, op, a, x, y);
    end
  endtask

  task automatic step(input logic [3:0] o, input logic [31:0] ia, ix, iy, input bit iss);
    logic [31:0] er, eacc;
    logic [8:0] ecc;
    @(negedge clk);
    chk("R13/R5 acc", acc, m_acc);
    op = o; a = ia; x = ix; y = iy; issue = iss;
    #1;
    model(o, ia, ix, iy, m_acc, er, ecc, eacc);
    chk(tag_of(o), r, er);
    chk("R10/R11/R12 cc", {23'd0, cc}, {23'd0, ecc});
    if (iss && o == 4'h7) m_acc = eacc;
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 6)
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'hffffffff;
      3: return 32'h7fffffff;
      4: return 32'h80000000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_acc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R13 reset acc", acc, 32'h0);
    // R1 clamp vs wrap on the extreme square
    step(4'h0, 32'h7fffffff, 32'h80000000, 32'h80000000, 1'b0);
    step(4'h2, 32'h7fffffff, 32'h80000000, 32'h80000000, 1'b0);
    // R2 floor rounding of a negative fraction
    step(4'h1, 32'h0, 32'h1, 32'h1, 1'b0);
    step(4'h3, 32'h80000000, 32'h7fffffff, 32'h7fffffff, 1'b0);
    // R3 integer clamp and 31-bit wrap
    step(4'h4, 32'h7fffffff, 32'h00010000, 32'h00010000, 1'b0);
    step(4'h5, 32'h3fffffff, 32'h1, 32'h1, 1'b0);
    // R4
    step(4'h6, 32'h80000000, 32'hffffffff, 32'hffffffff, 1'b0);
    // R6
    step(4'h8, 32'hf0f0f0f0, 32'h0ff00ff0, 32'h12345678, 1'b0);
    // R7 equal operands
    step(4'h9, 32'h5, 32'haaaa5555, 32'h5, 1'b0);
    step(4'hA, 32'h80000000, 32'h11, 32'h7fffffff, 1'b0);
    step(4'hB, 32'h7, 32'h22, 32'h7, 1'b0);
    // R8 interpolation endpoints
    step(4'hE, 32'h80000000, 32'h7fffffff, 32'h7fffffff, 1'b0);
    // R9
    step(4'hC, 32'hdeadbeef, 32'h1, 32'h2, 1'b1);
    step(4'hF, 32'h0, 32'h1, 32'h2, 1'b1);
    // R5 accumulate, including clamp and a non-issued move
    step(4'h7, 32'h1234, 32'h40000000, 32'h40000000, 1'b1);
    step(4'h7, 32'h1234, 32'h80000000, 32'h80000000, 1'b1);
    step(4'h7, 32'h1234, 32'h80000000, 32'h80000000, 1'b0);
    step(4'h0, 32'h0, 32'h0, 32'h0, 1'b1);
    for (int i = 0; i < 4000; i++)
      step(4'($urandom), pick(), pick(), pick(), 1'($urandom));
    step(4'h8, 32'h0, 32'h0, 32'h0, 1'b0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule